// File: doc/BRIEF.md
# PLL Digital Divider Chain

This block holds the digital dividers around a PLL frequency synthesizer core. It has three dividers. The first is a fixed divide-by-16 prescaler. It turns the reference clock into the comparison clock for the phase detector. The second is a programmable feedback divider. It runs on the VCO clock and emits one pulse every 2M VCO cycles. This means that in lock the VCO settles at the reference frequency times 2M/16. The third is an output divider. It scales the VCO clock by 1, 2, 4 or 8 with an even duty cycle.

The feedback divider and the output divider both take a new setting only at a terminal count. A divide word written in mid-period therefore cannot truncate a pulse or a clock phase. A separate combinational flag reports whether the current M word lies in the window where the loop can lock. The phase detector and the oscillator itself live outside this block.

Top module: `pll_divider_chain`

## Requirements
- R1: `ref_div_out` is `ref_clk` divided by 16 with 50% duty. It is low for the first 8 reference edges after reset is released and high for the next 8, and this pattern repeats.
- R2: `fb_pulse` is high for exactly one VCO cycle. It first rises on the first VCO edge after reset release and then once every 2M VCO edges.
- R3: `m_in_range` is 1 exactly when 125 <= `m_val` <= 350, and 0 for every other 9-bit value. It responds combinationally, with no clock delay.
- R4: `m_val` is sampled only on the VCO edge that raises `fb_pulse`. An M change made in the middle of an interval leaves that interval at the old length 2M_old.
- R5: The `n_sel` encoding selects the output ratio: 00 gives /1 (`out_clk` follows `vco_clk`), 01 gives /2, 10 gives /4 and 11 gives /8.
- R6: For /2, /4 and /8, each `out_clk` period is low for half the ratio in VCO cycles and then high for the other half. The first period starts low on the first VCO edge after reset.
- R7: `n_sel` is sampled only at the end of an `out_clk` period, that is, at the VCO edge that ends the high phase, or at every edge while in /1. A running period is never cut short.
- R8: `m_val` = 0 is treated as M = 1, so `fb_pulse` then repeats every 2 VCO cycles.
- R9: While `rst_n` is low, `ref_div_out` and `fb_pulse` are 0 and `out_clk` follows `vco_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| ref_clk | input | 1 | Crystal reference clock |
| vco_clk | input | 1 | VCO clock, modelled as a digital clock |
| m_val | input | 9 | Feedback multiplier M |
| n_sel | input | 2 | Output ratio select (00 /1, 01 /2, 10 /4, 11 /8) |
| ref_div_out | output | 1 | Reference divided by 16, to the phase detector |
| fb_pulse | output | 1 | One-cycle feedback pulse every 2M VCO cycles |
| out_clk | output | 1 | Divided output clock |
| m_in_range | output | 1 | High when M is in the lockable window |

## Verification
Each divider output comes from a register, so it changes one edge after the cause. `fb_pulse` and `out_clk` are sampled at the VCO falling edge that follows the rising edge being predicted. `ref_div_out` is sampled at the reference falling edge, against a count of reference rising edges since release. The bench models a change of `m_val` or `n_sel` made at falling edge k as first visible to rising edge k+1. Because of this, terminal counts that fall after the change pick up the new value, and earlier ones keep the old value. `m_in_range` is combinational and is checked 1 ns after each of the 512 input values is applied.

// File: rtl/pll_div_pkg.sv
`timescale 1ns/1ps
package pll_div_pkg;
  localparam int M_W      = 9;
  localparam int N_W      = 2;
  localparam int FB_W     = M_W + 1;
  localparam int OC_W     = (1 << N_W) - 1;
  localparam int PRE_LOG2 = 4;
  localparam int M_LO     = 125;
  localparam int M_HI     = 350;

  // reload value for a 2M-cycle feedback period; M=0 behaves as M=1
  function automatic logic [FB_W-1:0] fb_reload(input logic [M_W-1:0] m);
    if (m == '0) return FB_W'(1);
    return {m, 1'b0} - FB_W'(1);
  endfunction

  // half of the output ratio, minus one (phase counter reload)
  function automatic logic [OC_W-1:0] half_m1(input logic [N_W-1:0] n);
    int h;
    if (n == '0) return '0;
    h = 1 << (int'(n) - 1);
    return OC_W'(h - 1);
  endfunction

  function automatic logic m_lockable(input logic [M_W-1:0] m);
    return (int'(m) >= M_LO) && (int'(m) <= M_HI);
  endfunction
endpackage

// File: rtl/pll_ref_prescaler.sv
`timescale 1ns/1ps
module pll_ref_prescaler #(
  parameter int LOG2_DIV = pll_div_pkg::PRE_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  output logic div_out
);
  logic [LOG2_DIV-1:0] cnt;
  logic                wrap;

  assign wrap    = &cnt;
  assign div_out = cnt[LOG2_DIV-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // R1: the output ends its high half exactly on counter wrap
  assert_ref_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> $fell(div_out));
endmodule

// File: rtl/pll_fb_divider.sv
`timescale 1ns/1ps
module pll_fb_divider
  import pll_div_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  output logic           pulse
);
  logic [FB_W-1:0] cnt;
  logic            tc;

  assign tc = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (tc) begin
      cnt   <= fb_reload(m_val);
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt - 1'b1;
      pulse <= 1'b0;
    end
  end

  // R2: feedback pulse lasts one VCO cycle
  assert_fb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R4: between terminal counts the count only steps down, whatever M does
  assert_fb_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> (cnt == $past(cnt) - 1'b1));
  // R8: M=0 reloads a 2-cycle period
  assert_fb_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && m_val == '0) |=> (cnt == FB_W'(1)));
endmodule

// File: rtl/pll_out_divider.sv
`timescale 1ns/1ps
module pll_out_divider
  import pll_div_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] n_sel,
  output logic           out_clk
);
  logic [N_W-1:0]  n_act;
  logic [OC_W-1:0] cnt;
  logic            div_q;
  logic            tc;
  logic            bypass;
  logic            period_end;

  assign tc         = (cnt == '0);
  assign bypass     = (n_act == '0);
  assign period_end = bypass || (tc && div_q);
  assign out_clk    = bypass ? clk : div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_act <= '0;
      div_q <= 1'b0;
      cnt   <= '0;
    end else if (period_end) begin
      n_act <= n_sel;
      div_q <= 1'b0;
      cnt   <= half_m1(n_sel);
    end else if (tc) begin
      div_q <= 1'b1;
      cnt   <= half_m1(n_act);
    end else begin
      cnt   <= cnt - 1'b1;
    end
  end

  // R7: the ratio holds for the whole of a running period
  assert_n_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(n_act));
  // R6: low half ends by rising into the high half
  assert_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && tc && !div_q) |=> div_q);
endmodule

// File: rtl/pll_divider_chain.sv
`timescale 1ns/1ps
module pll_divider_chain
  import pll_div_pkg::*;
(
  input  logic           rst_n,
  input  logic           ref_clk,
  input  logic           vco_clk,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_sel,
  output logic           ref_div_out,
  output logic           fb_pulse,
  output logic           out_clk,
  output logic           m_in_range
);
  pll_ref_prescaler #(.LOG2_DIV(PRE_LOG2)) u_pre (
    .clk(ref_clk), .rst_n(rst_n), .div_out(ref_div_out));

  pll_fb_divider u_fb (
    .clk(vco_clk), .rst_n(rst_n), .m_val(m_val), .pulse(fb_pulse));

  pll_out_divider u_out (
    .clk(vco_clk), .rst_n(rst_n), .n_sel(n_sel), .out_clk(out_clk));

  assign m_in_range = m_lockable(m_val);

  always_comb begin
    if (rst_n && (int'(m_val) < M_LO || int'(m_val) > M_HI))
      assert_range_out_R3: assert (!m_in_range);
  end
endmodule

// File: tb/pll_divider_chain_test.sv
`timescale 1ns/1ps
module pll_divider_chain_test;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       vco_clk = 1'b0;
  logic [8:0] m_val = 9'd10;
  logic [1:0] n_sel = 2'd0;
  logic       ref_div_out, fb_pulse, out_clk, m_in_range;
  int checks = 0, fails = 0, redges = 0;
  bit done = 0;

  pll_divider_chain uut (.rst_n(rst_n), .ref_clk(ref_clk), .vco_clk(vco_clk),
    .m_val(m_val), .n_sel(n_sel), .ref_div_out(ref_div_out),
    .fb_pulse(fb_pulse), .out_clk(out_clk), .m_in_range(m_in_range));

  always #5 vco_clk = ~vco_clk;
  initial begin #3; forever #8 ref_clk = ~ref_clk; end

  always @(posedge ref_clk or negedge rst_n)
    if (!rst_n) redges <= 0; else redges <= redges + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge vco_clk); @(negedge vco_clk);
    rst_n = 1'b1;
  endtask

  // feedback: m1 until falling edge chg, then m2; one check per run
  task automatic run_fb(input int m1, input int chg, input int m2,
                        input int ncyc, input string req);
    int nxt = 1, bad = 0, a = 0, e = 0, at = 0;
    m_val = 9'(m1);
    do_reset();
    for (int k = 1; k <= ncyc; k++) begin
      bit exp;
      @(negedge vco_clk);
      exp = (k == nxt);
      if (fb_pulse !== exp && bad == 0) begin a = fb_pulse; e = exp; at = k; bad++; end
      if (exp) begin
        int mm = (k > chg) ? m2 : m1;
        nxt = k + 2 * ((mm == 0) ? 1 : mm);
      end
      if (k == chg) m_val = 9'(m2);
    end
    check(bad == 0, req, $sformatf("fb_pulse M=%0d->%0d edge %0d", m1, m2, at), a, e);
  endtask

  function automatic int half_of(input int n);
    return (n == 0) ? 0 : (1 << n) / 2;
  endfunction

  // output divider: n1 until falling edge chg, then n2
  task automatic run_out(input int n1, input int chg, input int n2,
                         input int ncyc, input string req);
    int ps = 1, hh = half_of(n1), bad = 0, a = 0, e = 0, at = 0;
    n_sel = 2'(n1);
    do_reset();
    for (int k = 1; k <= ncyc; k++) begin
      int plen;
      bit exp;
      @(negedge vco_clk);
      plen = (hh == 0) ? 1 : 2 * hh;
      if (k == ps + plen) begin
        ps = k;
        hh = half_of((k > chg) ? n2 : n1);
      end
      exp = (hh != 0) && ((k - ps) >= hh);
      if (out_clk !== exp && bad == 0) begin a = out_clk; e = exp; at = k; bad++; end
      if (k == chg) n_sel = 2'(n2);
    end
    check(bad == 0, req, $sformatf("out_clk N=%0d->%0d edge %0d", n1, n2, at), a, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    @(negedge vco_clk);
    check(ref_div_out === 1'b0, "R9", "ref_div_out in reset", ref_div_out, 0);
    check(fb_pulse === 1'b0, "R9", "fb_pulse in reset", fb_pulse, 0);
    check(out_clk === 1'b0, "R9", "out_clk low phase in reset", out_clk, 0);
    @(posedge vco_clk); #2;
    check(out_clk === 1'b1, "R9", "out_clk high phase in reset", out_clk, 1);

    // R3: exhaustive range flag sweep
    for (int m = 0; m < 512; m++) begin
      m_val = 9'(m); #1;
      check(m_in_range === ((m >= 125) && (m <= 350)), "R3",
            $sformatf("m_in_range M=%0d", m), m_in_range, (m >= 125) && (m <= 350));
    end

    // R1: reference prescaler
    begin
      int bad = 0, a = 0, e = 0;
      do_reset();
      for (int j = 0; j < 80; j++) begin
        @(negedge ref_clk);
        if (ref_div_out !== ((redges % 16) >= 8) && bad == 0) begin
          a = ref_div_out; e = ((redges % 16) >= 8); bad++;
        end
      end
      check(bad == 0, "R1", "ref_div_out /16 pattern", a, e);
    end

    // R2: feedback period sweep over small and boundary M
    for (int m = 1; m <= 12; m++) run_fb(m, 100000, m, 6 * m + 3, "R2");
    run_fb(125, 100000, 125, 760, "R2");
    run_fb(350, 100000, 350, 2110, "R2");
    run_fb(511, 100000, 511, 2050, "R2");
    // R8: M=0 acts as M=1
    run_fb(0, 100000, 0, 12, "R8");
    // R4: mid-interval M changes keep the running interval
    run_fb(10, 5, 3, 40, "R4");
    run_fb(3, 2, 7, 40, "R4");
    run_fb(4, 9, 0, 30, "R4");

    // R5/R6: every ratio, steady state
    for (int n = 1; n <= 3; n++) run_out(n, 100000, n, 40, "R6");
    run_out(0, 100000, 0, 20, "R5");
    begin
      n_sel = 2'd0; do_reset();
      @(posedge vco_clk); #2;
      check(out_clk === 1'b1, "R5", "out_clk /1 high after rise", out_clk, 1);
      @(negedge vco_clk); #2;
      check(out_clk === 1'b0, "R5", "out_clk /1 low after fall", out_clk, 0);
    end
    // R7: ratio changes wait for the period end
    run_out(3, 5, 1, 30, "R7");
    run_out(1, 2, 3, 30, "R7");
    run_out(2, 3, 0, 20, "R7");
    run_out(0, 4, 2, 30, "R7");
    run_out(3, 2, 2, 40, "R7");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule